// File: doc/BRIEF.md
# Flash Controller Interrupt Collector

This block gathers eight single-cycle event pulses from a serial flash controller's datapath and turns them into one level-sensitive interrupt line. Each event is latched into a raw status bit that stays set until software clears it by writing a one to the matching bit of the clear register. A mask register decides which latched events reach the interrupt line, and a masked-status view shows exactly which enabled events are pending.

The block also owns the datapath recovery control. Software writes a one to bit 0 of the recovery register. A small sequencer then holds a reset line toward the sequencer and both FIFOs for a fixed number of cycles, then waits one settle cycle. The recovery bit reads back as one for the whole sequence and falls to zero by itself, so software polls it to learn when recovery is complete.

Registers are reached through a simple word-indexed port: write enable, index and write data, with read data driven combinationally from the index. The recovery sequencer has three states: RV_IDLE, RV_HOLD and RV_SETTLE. Its transitions are: start (RV_IDLE to RV_HOLD, on an accepted recovery write), count (RV_HOLD to RV_HOLD while the hold counter has not reached its end), release (RV_HOLD to RV_SETTLE when the counter ends) and finish (RV_SETTLE to RV_IDLE).

Top module: `flash_irq_ctl`

## Requirements
- R1: After reset the mask register (index 0) reads all ones, raw status (index 2) reads zero, the interrupt and datapath reset outputs are low and the recovery register (index 4) reads zero.
- R2: A pulse on event input bit k sets raw status bit k at the next clock edge, whether bit k is masked or not, and the bit stays set until cleared. Bit meanings: 0 receive FIFO full, 1 receive underflow, 2 transmit overflow, 3 transmit empty, 4 transfer finished, 5 bus error, 6 serial protocol error, 7 DMA done.
- R3: A write to the clear register (index 1) clears every raw status bit whose write-data bit is 1; bits written as 0 leave raw status unchanged.
- R4: When an event pulse and a clear of the same bit fall in the same cycle, the raw bit is set after the edge.
- R5: A mask bit of 1 disables its source and 0 enables it; the masked status register (index 3) reads raw status AND NOT mask.
- R6: The interrupt output is high exactly when at least one masked status bit is 1.
- R7: A write with bit 0 set to the recovery register (index 4) drives the datapath reset output high for RST_HOLD cycles beginning at the next edge; recovery bit 0 reads 1 for RST_HOLD+1 cycles from that edge and then returns to 0.
- R8: A recovery write with bit 0 clear, or any recovery write while the sequence is running, has no effect.
- R9: The clear register and indices 5 to 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| event_i | input | NUM_SRC | Event pulses, one bit per source |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word index |
| reg_wdata | input | NUM_SRC | Register write data |
| reg_rdata | output | NUM_SRC | Register read data for reg_addr |
| dp_rst_o | output | 1 | Reset toward sequencer and FIFOs |
| irq_o | output | 1 | Combined interrupt line |

## Verification
The hardest situation to reach from the ports is an event arriving in the very cycle that software clears the same bit, because the two come from unrelated sides of the block. The vector table places an event pulse and a clear-register write in one row to force that collision, and it also clears a different pending bit in the same row so the rule is seen to act per bit. The recovery window is traced cycle by cycle, with a second recovery write issued mid-sequence to show it does not stretch the window.

// File: rtl/flash_irq_pkg.sv
package flash_irq_pkg;

    // register word indices
    localparam int IDX_MASK  = 0;
    localparam int IDX_CLEAR = 1;
    localparam int IDX_RAW   = 2;
    localparam int IDX_MSTAT = 3;
    localparam int IDX_RECOV = 4;

    typedef enum logic [1:0] {
        RV_IDLE   = 2'd0,
        RV_HOLD   = 2'd1,
        RV_SETTLE = 2'd2
    } recov_state_t;

endpackage

// File: rtl/irq_raw_bank.sv
module irq_raw_bank #(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] raw_o
);

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bit_q <= 1'b0;
            end else if (set_i[k]) begin
                bit_q <= 1'b1;          // event beats a same-cycle clear
            end else if (clr_i[k]) begin
                bit_q <= 1'b0;
            end
        end
        assign raw_o[k] = bit_q;
    end

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic [NUM_SRC-1:0] wdata_i,
    output logic [NUM_SRC-1:0] mask_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_o <= '1;
        end else if (wr_i) begin
            mask_o <= wdata_i;
        end
    end

endmodule

// File: rtl/recover_seq.sv
module recover_seq
    import flash_irq_pkg::*;
#(
    parameter int RST_HOLD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic dp_rst_o
);

    localparam int CNT_W = (RST_HOLD > 1) ? $clog2(RST_HOLD) : 1;
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(RST_HOLD - 1);

    recov_state_t state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RV_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            RV_IDLE: begin
                if (start_i) begin
                    state_d = RV_HOLD;      // start
                    cnt_d   = '0;
                end
            end
            RV_HOLD: begin
                if (cnt_q == CNT_END) begin
                    state_d = RV_SETTLE;    // release
                end else begin
                    cnt_d = cnt_q + 1'b1;   // count
                end
            end
            RV_SETTLE: begin
                state_d = RV_IDLE;          // finish
            end
            default: begin
                state_d = RV_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        busy_o   = 1'b1;
        dp_rst_o = 1'b0;
        unique case (state_q)
            RV_IDLE:   busy_o   = 1'b0;
            RV_HOLD:   dp_rst_o = 1'b1;
            RV_SETTLE: dp_rst_o = 1'b0;
            default:   busy_o   = 1'b0;
        endcase
    end

endmodule

// File: rtl/flash_irq_ctl.sv
module flash_irq_ctl
    import flash_irq_pkg::*;
#(
    parameter int NUM_SRC  = 8,
    parameter int ADDR_W   = 3,
    parameter int RST_HOLD = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] event_i,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [NUM_SRC-1:0] reg_wdata,
    output logic [NUM_SRC-1:0] reg_rdata,
    output logic               dp_rst_o,
    output logic               irq_o
);

    localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(IDX_MASK);
    localparam logic [ADDR_W-1:0] A_CLEAR = ADDR_W'(IDX_CLEAR);
    localparam logic [ADDR_W-1:0] A_RAW   = ADDR_W'(IDX_RAW);
    localparam logic [ADDR_W-1:0] A_MSTAT = ADDR_W'(IDX_MSTAT);
    localparam logic [ADDR_W-1:0] A_RECOV = ADDR_W'(IDX_RECOV);

    logic [NUM_SRC-1:0] raw_q;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] mstat;
    logic [NUM_SRC-1:0] clr_vec;
    logic               mask_wr;
    logic               rcv_start;
    logic               rcv_busy;

    assign mask_wr   = reg_we && (reg_addr == A_MASK);
    assign clr_vec   = (reg_we && (reg_addr == A_CLEAR)) ? reg_wdata : '0;
    assign rcv_start = reg_we && (reg_addr == A_RECOV) && reg_wdata[0];

    irq_raw_bank #(.NUM_SRC(NUM_SRC)) u_raw (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (event_i),
        .clr_i (clr_vec),
        .raw_o (raw_q)
    );

    irq_mask_reg #(.NUM_SRC(NUM_SRC)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (mask_wr),
        .wdata_i (reg_wdata),
        .mask_o  (mask_q)
    );

    recover_seq #(.RST_HOLD(RST_HOLD)) u_recov (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (rcv_start),
        .busy_o   (rcv_busy),
        .dp_rst_o (dp_rst_o)
    );

    assign mstat = raw_q & ~mask_q;
    assign irq_o = |mstat;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_MASK:  reg_rdata = mask_q;
            A_RAW:   reg_rdata = raw_q;
            A_MSTAT: reg_rdata = mstat;
            A_RECOV: reg_rdata[0] = rcv_busy;
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/flash_irq_ctl_chk.sv
module flash_irq_ctl_chk
    import flash_irq_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int ADDR_W  = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] event_i,
    input logic               reg_we,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [NUM_SRC-1:0] reg_wdata,
    input logic [NUM_SRC-1:0] raw_q,
    input logic [NUM_SRC-1:0] mask_q,
    input logic               rcv_busy,
    input logic               dp_rst_o,
    input logic               irq_o
);

    logic clr_wr;
    logic rcv_wr;
    assign clr_wr = reg_we && (reg_addr == ADDR_W'(IDX_CLEAR));
    assign rcv_wr = reg_we && (reg_addr == ADDR_W'(IDX_RECOV));

    // R2, R4: every pulsed event is latched at the next edge
    a_r2_event_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (|event_i) |=> ((raw_q & $past(event_i)) == $past(event_i)));

    // R3: cleared bits drop when no event competes
    a_r3_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && event_i == '0) |=> ((raw_q & $past(reg_wdata)) == '0));

    // R3: without a clear write no raw bit falls
    a_r3_no_spurious_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_wr) |=> ((raw_q & $past(raw_q)) == $past(raw_q)));

    // R6: interrupt follows pending enabled sources
    a_r6_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (|(raw_q & ~mask_q)));

    // R7: datapath reset only inside the busy window
    a_r7_rst_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        dp_rst_o |-> rcv_busy);

    // R7: accepted recovery write starts the reset
    a_r7_start: assert property (@(posedge clk) disable iff (!rst_n)
        (rcv_wr && reg_wdata[0] && !rcv_busy) |=> (rcv_busy && dp_rst_o));

    // R8: a write with bit 0 clear does not start recovery
    a_r8_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
        (rcv_wr && !reg_wdata[0] && !rcv_busy) |=> !rcv_busy);

endmodule

bind flash_irq_ctl flash_irq_ctl_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .event_i   (event_i),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .raw_q     (raw_q),
    .mask_q    (mask_q),
    .rcv_busy  (rcv_busy),
    .dp_rst_o  (dp_rst_o),
    .irq_o     (irq_o)
);

// File: tb/flash_irq_ctl_test.sv
`timescale 1ns/100ps
module flash_irq_ctl_test;

    localparam int N    = 8;
    localparam int AW   = 3;
    localparam int HOLD = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  event_i = '0;
    logic          reg_we = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [N-1:0]  reg_wdata = '0;
    logic [N-1:0]  reg_rdata;
    logic          dp_rst_o;
    logic          irq_o;

    int tests = 0;
    int fails = 0;
    logic [N-1:0] mask_m = '1;

    always #2 clk = ~clk;

    flash_irq_ctl #(.NUM_SRC(N), .ADDR_W(AW), .RST_HOLD(HOLD)) uut (
        .clk(clk), .rst_n(rst_n), .event_i(event_i), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dp_rst_o(dp_rst_o), .irq_o(irq_o)
    );

    // {events[28:21], we[20], addr[19:17], wdata[16:9], exp_raw[8:1], exp_irq[0]}
    localparam int NV = 12;
    localparam logic [28:0] VEC [NV] = '{
        {8'h01, 1'b0, 3'd0, 8'h00, 8'h01, 1'b0},  // R2 masked event latched
        {8'h80, 1'b0, 3'd0, 8'h00, 8'h81, 1'b0},  // R2 DMA done
        {8'h00, 1'b1, 3'd0, 8'hFE, 8'h81, 1'b1},  // R5 unmask bit 0
        {8'h00, 1'b1, 3'd1, 8'h01, 8'h80, 1'b0},  // R3 clear bit 0
        {8'h00, 1'b1, 3'd1, 8'h00, 8'h80, 1'b0},  // R3 zero write
        {8'h00, 1'b1, 3'd0, 8'h7F, 8'h80, 1'b1},  // R6 unmask bit 7
        {8'h24, 1'b0, 3'd0, 8'h00, 8'hA4, 1'b1},  // R2 two events
        {8'h00, 1'b1, 3'd1, 8'h80, 8'h24, 1'b0},  // R3 clear bit 7
        {8'h00, 1'b1, 3'd0, 8'hDB, 8'h24, 1'b1},  // R5 enable 2 and 5
        {8'h20, 1'b1, 3'd1, 8'h24, 8'h20, 1'b1},  // R4 event beats clear
        {8'h00, 1'b1, 3'd1, 8'h20, 8'h00, 1'b0},  // R3 clear last
        {8'h00, 1'b1, 3'd0, 8'hFF, 8'h00, 1'b0}   // R5 mask all
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic step(input logic [N-1:0] ev, input logic we,
                        input logic [AW-1:0] a, input logic [N-1:0] wd);
        @(negedge clk);
        event_i = ev; reg_we = we; reg_addr = a; reg_wdata = wd;
        @(posedge clk);
        #1;
        event_i = '0; reg_we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [N-1:0] v);
        reg_addr = a;
        #0.5;
        v = reg_rdata;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
        $finish;
    end

    initial begin : main
        logic [N-1:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R1 reset state
        rd(3'd0, v); check("R1 mask", 32'(v), 32'hFF);
        rd(3'd2, v); check("R1 raw", 32'(v), 32'h00);
        rd(3'd4, v); check("R1 recov", 32'(v), 32'h00);
        check("R1 irq", 32'(irq_o), 32'd0);
        check("R1 dp_rst", 32'(dp_rst_o), 32'd0);

        // vector table: R2 R3 R4 R5 R6
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][28:21], VEC[i][20], VEC[i][19:17], VEC[i][16:9]);
            if (VEC[i][20] && VEC[i][19:17] == 3'd0) mask_m = VEC[i][16:9];
            rd(3'd2, v); check($sformatf("R2/R3/R4 raw row %0d", i), 32'(v), 32'(VEC[i][8:1]));
            check($sformatf("R6 irq row %0d", i), 32'(irq_o), 32'(VEC[i][0]));
            rd(3'd3, v); check($sformatf("R5 mstat row %0d", i), 32'(v), 32'(VEC[i][8:1] & ~mask_m));
        end

        // R9 clear and unused indices read zero
        step(8'h18, 1'b0, 3'd0, 8'h00);
        rd(3'd1, v); check("R9 clear reads 0", 32'(v), 32'h0);
        rd(3'd5, v); check("R9 idx5", 32'(v), 32'h0);
        rd(3'd7, v); check("R9 idx7", 32'(v), 32'h0);
        step(8'h00, 1'b1, 3'd1, 8'h18);

        // R8 zero write to recovery ignored
        step(8'h00, 1'b1, 3'd4, 8'hFE);
        rd(3'd4, v); check("R8 zero write", 32'(v), 32'h0);
        check("R8 dp_rst idle", 32'(dp_rst_o), 32'd0);

        // R7 recovery window
        step(8'h00, 1'b1, 3'd4, 8'h01);
        for (int c = 0; c < HOLD; c++) begin
            rd(3'd4, v);
            check($sformatf("R7 busy hold %0d", c), 32'(v), 32'h1);
            check($sformatf("R7 dp_rst hold %0d", c), 32'(dp_rst_o), 32'd1);
            if (c == 1) begin
                // R8 rewrite while busy does not extend the window
                step(8'h00, 1'b1, 3'd4, 8'h01);
            end else begin
                @(posedge clk); #1;
            end
        end
        rd(3'd4, v); check("R7 settle busy", 32'(v), 32'h1);
        check("R7 settle dp_rst", 32'(dp_rst_o), 32'd0);
        @(posedge clk); #1;
        rd(3'd4, v); check("R7 self clear", 32'(v), 32'h0);
        check("R8 no restart", 32'(dp_rst_o), 32'd0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule